// File: doc/BRIEF.md
# Setup-Masked Memory Window Register

This block is the base address register for one memory window of a bridge-style device. It has two write sources. A local load port fills a companion setup word before the host may touch the register. The host configuration port then writes and reads the base address. The setup word decides three things: which base-address bits the host can write, and so the window size; whether the window is prefetchable; and whether the window is enabled at all.

A lockout flag comes out of reset set. While it is set, setup loads are taken and host writes are dropped. A single pulse on `host_unlock` clears the flag until the next reset. Once it is clear, the setup word is frozen and host writes take effect.

Each incoming transaction address is compared with the stored base over the writable bit positions only. The hit flag rises when the address lies inside an enabled window. The window granularity is 4 KB. Setting the parameter `IS_WIDE` builds a variant with 64-bit addresses. That variant adds a second setup word and a second base word, which together cover address bits 63:32.

Top module: `membar_window`

## Requirements
- R1: In the lower BAR read word, bit 0 and bits 11:4 always read 0, whatever the host writes.
- R2: Lower BAR bits 2:1 read 00 when `IS_WIDE`=0 and 10 when `IS_WIDE`=1.
- R3: Lower BAR bit 3 reads the setup prefetch bit (setup data bit 3 of a lower load) when the window is enabled, and reads 0 while the window is disabled.
- R4: Each base bit at position 12 and up is writable only where the matching setup mask bit is 1. At those positions it reads the last value written. At every other position it reads 0.
- R5: The setup mask is taken from setup data bits 31:12 on a lower load (`setup_sel`=0). The 32-bit window is enabled exactly when mask bit 31 is 1. The 64-bit window is enabled when lower mask bit 31 or upper mask bit 31 is 1.
- R6: After reset, the lower BAR reads 0 apart from its type bits, the upper BAR reads 0, the window is disabled, and the lockout is set.
- R7: Setup loads take effect only while the lockout is set. Once `host_unlock` has pulsed, later loads are ignored, and the lockout stays clear until reset.
- R8: Host writes to the BAR are ignored while the lockout is set.
- R9: `txn_hit` is 1 exactly when the window is enabled and the address equals the stored base at every writable mask position. While the window is disabled it is 0.
- R10: With `IS_WIDE`=1, writes and loads with select 1 act on the upper base and upper setup words, which cover address bits 63:32. With `IS_WIDE`=0, the upper BAR reads 0 and select-1 accesses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_unlock | input | 1 | Pulse that clears the lockout flag |
| setup_we | input | 1 | Setup load strobe |
| setup_sel | input | 1 | Setup word select: 0 lower, 1 upper |
| setup_data | input | 32 | Setup load data |
| cfg_we | input | 1 | Host BAR write strobe |
| cfg_sel | input | 1 | BAR word select: 0 lower, 1 upper |
| cfg_wdata | input | 32 | Host BAR write data |
| cfg_rdata_lo | output | 32 | Lower BAR read value |
| cfg_rdata_hi | output | 32 | Upper BAR read value |
| txn_addr | input | 32 or 64 | Transaction address to decode |
| txn_hit | output | 1 | Address falls in the enabled window |

## Verification
The bench builds two instances side by side on shared stimulus. One uses `IS_WIDE`=0 and the other `IS_WIDE`=1. Because both see the same loads and writes, the same setup data enables one window and leaves the other disabled, which exercises the alternate enable path through upper setup bit 31. The wide build also reaches the type encoding 10 and the upper base compare. The narrow build shows that select-1 traffic is dropped.

// File: rtl/membar_pkg.sv
package membar_pkg;
  localparam int WORD_W    = 32;
  localparam int GRAN_LOG2 = 12;
  localparam int LO_MASK_W = WORD_W - GRAN_LOG2;
  localparam int PREF_BIT  = 3;

  typedef enum logic [1:0] {
    LOC_ANY32 = 2'b00,
    LOC_ANY64 = 2'b10
  } mem_loc_e;
endpackage

// File: rtl/membar_rst_sync.sv
module membar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/membar_setup_reg.sv
module membar_setup_reg
  import membar_pkg::*;
#(
  parameter bit IS_WIDE = 1'b0,
  parameter int MASK_W  = LO_MASK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlock_i,
  input  logic              ld_we_i,
  input  logic              ld_sel_i,
  input  logic [WORD_W-1:0] ld_data_i,
  output logic              lock_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              pref_o,
  output logic              en_o
);
  logic                 lock_q, lock_d;
  logic                 pref_q, pref_d;
  logic [LO_MASK_W-1:0] mask_lo_q, mask_lo_d;
  logic                 load_ok;
  logic                 unused_bits;

  assign load_ok     = ld_we_i && lock_q;
  assign unused_bits = ^{ld_data_i[GRAN_LOG2-1:PREF_BIT+1], ld_data_i[PREF_BIT-1:0]};

  always_comb begin
    lock_d    = lock_q & ~unlock_i;
    pref_d    = pref_q;
    mask_lo_d = mask_lo_q;
    if (load_ok && !ld_sel_i) begin
      mask_lo_d = ld_data_i[WORD_W-1:GRAN_LOG2];
      pref_d    = ld_data_i[PREF_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q    <= 1'b1;
      pref_q    <= 1'b0;
      mask_lo_q <= '0;
    end else begin
      lock_q    <= lock_d;
      pref_q    <= pref_d;
      mask_lo_q <= mask_lo_d;
    end
  end

  generate
    if (IS_WIDE) begin : g_wide
      logic [WORD_W-1:0] mask_hi_q, mask_hi_d;

      always_comb begin
        mask_hi_d = mask_hi_q;
        if (load_ok && ld_sel_i) mask_hi_d = ld_data_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_hi_q <= '0;
        else        mask_hi_q <= mask_hi_d;
      end

      assign mask_o = {mask_hi_q, mask_lo_q};
      assign en_o   = mask_lo_q[LO_MASK_W-1] | mask_hi_q[WORD_W-1];
    end else begin : g_narrow
      assign mask_o = mask_lo_q;
      assign en_o   = mask_lo_q[LO_MASK_W-1];
    end
  endgenerate

  assign lock_o = lock_q;
  assign pref_o = pref_q;

  AST_SETUP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> ($stable(mask_o) && $stable(pref_q))); // R7
  AST_LOCK_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_q |=> !lock_q); // R7
endmodule

// File: rtl/membar_base_reg.sv
module membar_base_reg
  import membar_pkg::*;
#(
  parameter bit IS_WIDE = 1'b0,
  parameter int MASK_W  = LO_MASK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_allow_i,
  input  logic              wr_we_i,
  input  logic              wr_sel_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [MASK_W-1:0] base_o
);
  logic [LO_MASK_W-1:0] base_lo_q, base_lo_d;
  logic                 wr_ok;
  logic                 unused_bits;

  assign wr_ok       = wr_we_i && wr_allow_i;
  assign unused_bits = ^wr_data_i[GRAN_LOG2-1:0];

  always_comb begin
    base_lo_d = base_lo_q;
    if (wr_ok && !wr_sel_i)
      base_lo_d = wr_data_i[WORD_W-1:GRAN_LOG2] & mask_i[LO_MASK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_lo_q <= '0;
    else        base_lo_q <= base_lo_d;
  end

  generate
    if (IS_WIDE) begin : g_wide
      logic [WORD_W-1:0] base_hi_q, base_hi_d;

      always_comb begin
        base_hi_d = base_hi_q;
        if (wr_ok && wr_sel_i)
          base_hi_d = wr_data_i & mask_i[MASK_W-1:LO_MASK_W];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) base_hi_q <= '0;
        else        base_hi_q <= base_hi_d;
      end

      assign base_o = {base_hi_q, base_lo_q};
    end else begin : g_narrow
      assign base_o = base_lo_q;
    end
  endgenerate

  AST_BASE_HELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_allow_i |=> $stable(base_o)); // R8
  AST_BASE_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (base_o & ~mask_i) == '0); // R4
endmodule

// File: rtl/membar_addr_match.sv
module membar_addr_match
  import membar_pkg::*;
#(
  parameter int ADDR_W = WORD_W,
  parameter int MASK_W = ADDR_W - GRAN_LOG2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MASK_W-1:0] base_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              en_i,
  output logic              hit_o
);
  logic [MASK_W-1:0] diff;
  logic              unused_low;

  assign unused_low = ^addr_i[GRAN_LOG2-1:0];

  always_comb begin
    diff  = (addr_i[ADDR_W-1:GRAN_LOG2] ^ base_i) & mask_i;
    hit_o = en_i && (diff == '0);
  end
endmodule

// File: rtl/membar_window.sv
module membar_window
  import membar_pkg::*;
#(
  parameter bit IS_WIDE = 1'b0,
  localparam int ADDR_W = IS_WIDE ? 2 * WORD_W : WORD_W,
  localparam int MASK_W = ADDR_W - GRAN_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_unlock,
  input  logic              setup_we,
  input  logic              setup_sel,
  input  logic [WORD_W-1:0] setup_data,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata_lo,
  output logic [WORD_W-1:0] cfg_rdata_hi,
  input  logic [ADDR_W-1:0] txn_addr,
  output logic              txn_hit
);
  logic              rst_sync_n;
  logic              locked;
  logic [MASK_W-1:0] win_mask;
  logic [MASK_W-1:0] win_base;
  logic              win_pref;
  logic              win_en;
  mem_loc_e          loc_type;

  membar_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  membar_setup_reg #(.IS_WIDE(IS_WIDE), .MASK_W(MASK_W)) i_setup (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .unlock_i  (host_unlock),
    .ld_we_i   (setup_we),
    .ld_sel_i  (setup_sel),
    .ld_data_i (setup_data),
    .lock_o    (locked),
    .mask_o    (win_mask),
    .pref_o    (win_pref),
    .en_o      (win_en)
  );

  membar_base_reg #(.IS_WIDE(IS_WIDE), .MASK_W(MASK_W)) i_base (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_allow_i (!locked),
    .wr_we_i    (cfg_we),
    .wr_sel_i   (cfg_sel),
    .wr_data_i  (cfg_wdata),
    .mask_i     (win_mask),
    .base_o     (win_base)
  );

  membar_addr_match #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) i_match (
    .addr_i (txn_addr),
    .base_i (win_base),
    .mask_i (win_mask),
    .en_i   (win_en),
    .hit_o  (txn_hit)
  );

  assign loc_type = IS_WIDE ? LOC_ANY64 : LOC_ANY32;

  always_comb begin
    cfg_rdata_lo = '0;
    cfg_rdata_lo[WORD_W-1:GRAN_LOG2] = win_base[LO_MASK_W-1:0];
    cfg_rdata_lo[PREF_BIT]           = win_pref & win_en;
    cfg_rdata_lo[2:1]                = loc_type;
  end

  generate
    if (IS_WIDE) begin : g_hi_rd
      assign cfg_rdata_hi = win_base[MASK_W-1:LO_MASK_W];
    end else begin : g_hi_zero
      assign cfg_rdata_hi = '0;
    end
  endgenerate

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_rdata_lo[0] == 1'b0) && (cfg_rdata_lo[GRAN_LOG2-1:PREF_BIT+1] == '0)); // R1
  AST_NO_HIT_DISABLED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !win_en |-> !txn_hit); // R9
endmodule

// File: tb/test_membar_window.sv
module test_membar_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_unlock = 1'b0;
  logic        setup_we = 1'b0;
  logic        setup_sel = 1'b0;
  logic [31:0] setup_data = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] n_rd_lo, n_rd_hi, w_rd_lo, w_rd_hi;
  logic [31:0] n_addr = '0;
  logic [63:0] w_addr = '0;
  logic        n_hit, w_hit;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  membar_window #(.IS_WIDE(1'b0)) i_membar_window (
    .clk(clk), .rst_n(rst_n), .host_unlock(host_unlock),
    .setup_we(setup_we), .setup_sel(setup_sel), .setup_data(setup_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata_lo(n_rd_lo), .cfg_rdata_hi(n_rd_hi),
    .txn_addr(n_addr), .txn_hit(n_hit)
  );

  membar_window #(.IS_WIDE(1'b1)) i_membar_window_wide (
    .clk(clk), .rst_n(rst_n), .host_unlock(host_unlock),
    .setup_we(setup_we), .setup_sel(setup_sel), .setup_data(setup_data),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata_lo(w_rd_lo), .cfg_rdata_hi(w_rd_hi),
    .txn_addr(w_addr), .txn_hit(w_hit)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_setup(input logic sel, input logic [31:0] d);
    setup_sel = sel; setup_data = d; setup_we = 1'b1;
    @(negedge clk);
    setup_we = 1'b0;
  endtask

  task automatic host_write(input logic sel, input logic [31:0] d);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic unlock();
    host_unlock = 1'b1;
    @(negedge clk);
    host_unlock = 1'b0;
  endtask

  task automatic probe(input logic [31:0] na, input logic [63:0] wa);
    n_addr = na; w_addr = wa;
    #1;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R6 narrow lo", n_rd_lo, 32'h0);
    chk("R6 narrow hi", n_rd_hi, 32'h0);
    chk("R2 wide type after reset", w_rd_lo, 32'h4);
    chk("R6 wide hi", w_rd_hi, 32'h0);
    probe(32'h0, 64'h0);
    chk("R6 narrow no hit", n_hit, 0);
    chk("R6 wide no hit", w_hit, 0);
  endtask

  task automatic t_locked_then_unlock();
    host_write(1'b0, 32'hFFFF_FFFF);
    chk("R8 narrow write ignored while locked", n_rd_lo, 32'h0);
    chk("R8 wide write ignored while locked", w_rd_lo, 32'h4);
    load_setup(1'b0, 32'hFFF0_0008);
    load_setup(1'b1, 32'hFFFF_FFFF);
    unlock();
    load_setup(1'b0, 32'h0000_0000);
    load_setup(1'b1, 32'h0000_0000);
    host_write(1'b0, 32'hFFFF_FFFF);
    chk("R7 R4 R3 narrow setup frozen", n_rd_lo, 32'hFFF0_0008);
    chk("R7 R2 wide setup frozen", w_rd_lo, 32'hFFF0_000C);
    host_write(1'b1, 32'hFFFF_FFFF);
    chk("R10 wide upper base", w_rd_hi, 32'hFFFF_FFFF);
    chk("R10 narrow upper reads 0", n_rd_hi, 32'h0);
  endtask

  task automatic t_decode();
    host_write(1'b0, 32'h1234_5678);
    chk("R4 R1 narrow masked base", n_rd_lo, 32'h1230_0008);
    chk("R4 wide masked base", w_rd_lo, 32'h1230_000C);
    host_write(1'b1, 32'h0000_00AB);
    chk("R10 wide upper value", w_rd_hi, 32'h0000_00AB);
    probe(32'h123A_BCDE, 64'h0000_00AB_123F_FFFF);
    chk("R9 narrow hit", n_hit, 1);
    chk("R9 wide hit", w_hit, 1);
    probe(32'h1240_0000, 64'h0000_00AC_1230_0000);
    chk("R9 narrow miss", n_hit, 0);
    chk("R10 wide miss on upper bits", w_hit, 0);
  endtask

  task automatic t_enable_paths();
    do_reset();
    load_setup(1'b0, 32'h7FF0_0008);
    load_setup(1'b1, 32'h8000_0000);
    unlock();
    host_write(1'b0, 32'hFFFF_FFFF);
    chk("R3 R5 narrow disabled pref 0", n_rd_lo, 32'h7FF0_0000);
    chk("R5 wide enabled by upper bit", w_rd_lo, 32'h7FF0_000C);
    host_write(1'b1, 32'hFFFF_FFFF);
    chk("R10 R4 wide upper mask", w_rd_hi, 32'h8000_0000);
    probe(32'h7FF0_0000, 64'h8000_0000_7FF0_0000);
    chk("R9 narrow disabled never hits", n_hit, 0);
    chk("R5 wide hit", w_hit, 1);
    probe(32'h0, 64'h0000_0000_7FF0_0000);
    chk("R9 wide miss bit 63", w_hit, 0);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_locked_then_unlock();
    t_decode();
    t_enable_paths();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule